// File: doc/BRIEF.md
# Logical-Register Wakeup and Select Array

This block is the wakeup and select core of an issue queue whose rows hold instructions in program order and whose columns stand for logical registers. Each row records which logical registers it reads and which it writes. Readiness runs down every column from older rows to younger ones. A row that writes a register and has not yet issued holds that column low for every younger row, so dependences are resolved by position and register number alone. No renaming and no physical-tag broadcast take part in wakeup.

The queue is a circular buffer split into segments as wide as the dispatch group. One segment, named by an input pointer, is the architected segment: it holds the oldest rows, and the readiness entering it is taken as fully ready. A column signal crosses at most `HOP` rows in one cycle. Beyond that it passes through a register into the next hop group. An oldest-first selector grants up to `ISSUE_W` requesting rows per cycle. In loop mode a commit pulse re-arms a row for its next iteration instead of freeing it. A flush clears every row younger than a given row.

Top module: `wk_logreg_sched`

## Requirements
- R1: After reset no row is valid, and both `req` and `grant` are all zero.
- R2: A valid row requests only when it has not been granted, its settle delay has run out, and every logical register it reads sees an asserted column ready at its position.
- R3: A valid row that writes a register and has not been granted deasserts that column for all younger rows. From the cycle after its grant it reasserts the column. Three rows that each read and write register 0 issue in three consecutive cycles, oldest first.
- R4: At most `ISSUE_W` rows are granted per cycle. Each grant is a requesting row. Rows are chosen by age, counted from the first row of the architected segment (row `arch_seg*SEG`) and wrapping at `ROWS`. A granted row does not request again until it is re-armed.
- R5: The first row of the architected segment sees every column as ready, whatever younger rows (those placed before it in the circular order) hold.
- R6: Column readiness crosses the boundary between hop groups of `HOP` rows through a register. A consumer in the next group therefore wakes one cycle later than a consumer in the same group would.
- R7: A row that has just been inserted or re-armed does not request for `ROWS/HOP - 1` cycles (1 cycle with the defaults).
- R8: A commit pulse on a row frees it when `loop_mode` is 0. When `loop_mode` is 1 it clears only the row's grant, so the row waits out its settle delay and then re-evaluates against the current column ready.
- R9: A flush frees every row whose age is greater than the age of `flush_row`. The flush row and all older rows keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arch_seg | input | log2(ROWS/SEG) | Index of the architected (oldest) segment |
| loop_mode | input | 1 | Commit re-arms rows instead of freeing them |
| ins_vld | input | NUM_INS | Insert enable per insert port |
| ins_row | input | NUM_INS x log2(ROWS) | Target row per insert port |
| ins_src | input | NUM_INS x LREGS | Logical registers read, one bit per register |
| ins_dst | input | NUM_INS x LREGS | Logical registers written, one bit per register |
| commit | input | ROWS | Commit pulse per row |
| flush_vld | input | 1 | Flush rows younger than `flush_row` |
| flush_row | input | log2(ROWS) | Youngest row kept by a flush |
| req | output | ROWS | Issue request per row |
| grant | output | ROWS | Issue grant per row from the oldest-first select |

## Verification
The bench runs a chain of three rows that all read and write register 0 against four rows that write distinct registers and read none. The first must issue one row per cycle. The second must issue two rows per cycle, which separates column blocking from the issue-width limit. A producer and consumer placed on either side of a hop boundary must show one extra cycle of latency compared with the same-group chain. Moving the architected segment to the middle of the queue shows both the wrap-around age order and the forced-ready entry of the oldest segment. Loop-mode commits against plain commits, and a flush in the middle of a chain, show whether rows re-arm, vanish or survive as required.

// File: rtl/wk_pkg.sv
`timescale 1ns/1ps
package wk_pkg;
    localparam int DEF_ROWS    = 16;
    localparam int DEF_LREGS   = 8;
    localparam int DEF_SEG     = 4;
    localparam int DEF_ISSUE_W = 2;
    localparam int DEF_HOP     = 8;
    localparam int DEF_NUM_INS = 4;

    // width of a counter holding values 0..n-1, never below one bit
    function automatic int cnt_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/wk_ready_chain.sv
`timescale 1ns/1ps
module wk_ready_chain #(
    parameter int ROWS     = 16,
    parameter int LREGS    = 8,
    parameter int HOP_ROWS = 8,
    parameter int IDXW     = 4,
    parameter int NHOPS    = ROWS / HOP_ROWS
) (
    input  logic [ROWS-1:0]             pend,
    input  logic [ROWS-1:0][LREGS-1:0]  dst,
    input  logic [IDXW-1:0]             start,
    input  logic [NHOPS-1:0][LREGS-1:0] hop_q,
    output logic [ROWS-1:0][LREGS-1:0]  col_in,
    output logic [NHOPS-1:0][LREGS-1:0] hop_d
);
    logic [NHOPS-1:0][LREGS-1:0] grp_out;

    always_comb begin
        logic [LREGS-1:0] run;
        col_in = '0;
        for (int g = 0; g < NHOPS; g++) begin
            run = hop_q[g];
            for (int r = 0; r < HOP_ROWS; r++) begin
                // oldest row of the queue: operands are architected
                if (IDXW'(g * HOP_ROWS + r) == start) run = '1;
                col_in[g * HOP_ROWS + r] = run;
                run = run & ~(pend[g * HOP_ROWS + r] ? dst[g * HOP_ROWS + r] : '0);
            end
            grp_out[g] = run;
        end
        for (int g = 0; g < NHOPS; g++)
            hop_d[g] = grp_out[(g + NHOPS - 1) % NHOPS];
    end
endmodule

// File: rtl/wk_oldest_select.sv
`timescale 1ns/1ps
module wk_oldest_select #(
    parameter int ROWS    = 16,
    parameter int ISSUE_W = 2,
    parameter int IDXW    = 4
) (
    input  logic [ROWS-1:0] req,
    input  logic [IDXW-1:0] start,
    output logic [ROWS-1:0] grant
);
    always_comb begin
        int taken;
        taken = 0;
        grant = '0;
        for (int k = 0; k < ROWS; k++) begin
            if (req[(int'(start) + k) % ROWS] && taken < ISSUE_W) begin
                grant[(int'(start) + k) % ROWS] = 1'b1;
                taken = taken + 1;
            end
        end
    end
endmodule

// File: rtl/wk_logreg_sched.sv
`timescale 1ns/1ps
module wk_logreg_sched
    import wk_pkg::*;
#(
    parameter int ROWS    = DEF_ROWS,
    parameter int LREGS   = DEF_LREGS,
    parameter int SEG     = DEF_SEG,
    parameter int ISSUE_W = DEF_ISSUE_W,
    parameter int HOP     = DEF_HOP,
    parameter int NUM_INS = DEF_NUM_INS,
    localparam int IDXW   = $clog2(ROWS),
    localparam int SEGW   = cnt_w(ROWS / SEG)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [SEGW-1:0]                     arch_seg,
    input  logic                                loop_mode,
    input  logic [NUM_INS-1:0]                  ins_vld,
    input  logic [NUM_INS-1:0][IDXW-1:0]        ins_row,
    input  logic [NUM_INS-1:0][LREGS-1:0]       ins_src,
    input  logic [NUM_INS-1:0][LREGS-1:0]       ins_dst,
    input  logic [ROWS-1:0]                     commit,
    input  logic                                flush_vld,
    input  logic [IDXW-1:0]                     flush_row,
    output logic [ROWS-1:0]                     req,
    output logic [ROWS-1:0]                     grant
);
    localparam int HOP_ROWS = (HOP < ROWS) ? HOP : ROWS;
    localparam int NHOPS    = ROWS / HOP_ROWS;
    localparam int SETW     = cnt_w(NHOPS);
    localparam logic [SETW-1:0] SETTLE_INIT = SETW'(NHOPS - 1);

    typedef struct packed {
        logic [ROWS-1:0]             valid;
        logic [ROWS-1:0]             granted;
        logic [ROWS-1:0][LREGS-1:0]  src;
        logic [ROWS-1:0][LREGS-1:0]  dst;
        logic [ROWS-1:0][SETW-1:0]   settle;
        logic [NHOPS-1:0][LREGS-1:0] hop;
    } state_t;

    state_t q, d;

    logic [IDXW-1:0]             start;
    logic [ROWS-1:0]             pend;
    logic [ROWS-1:0][LREGS-1:0]  col_in;
    logic [NHOPS-1:0][LREGS-1:0] hop_d;
    logic [IDXW-1:0]             flush_age;

    assign start     = IDXW'(int'(arch_seg) * SEG);
    assign pend      = q.valid & ~q.granted;
    assign flush_age = flush_row - start;

    wk_ready_chain #(
        .ROWS(ROWS), .LREGS(LREGS), .HOP_ROWS(HOP_ROWS), .IDXW(IDXW), .NHOPS(NHOPS)
    ) u_chain (
        .pend(pend), .dst(q.dst), .start(start), .hop_q(q.hop),
        .col_in(col_in), .hop_d(hop_d)
    );

    always_comb begin
        for (int i = 0; i < ROWS; i++)
            req[i] = pend[i] && (q.settle[i] == '0) && ((q.src[i] & ~col_in[i]) == '0);
    end

    wk_oldest_select #(
        .ROWS(ROWS), .ISSUE_W(ISSUE_W), .IDXW(IDXW)
    ) u_sel (
        .req(req), .start(start), .grant(grant)
    );

    always_comb begin
        d     = q;
        d.hop = hop_d;
        for (int i = 0; i < ROWS; i++) begin
            if (q.settle[i] != '0) d.settle[i] = q.settle[i] - 1'b1;
            if (grant[i]) d.granted[i] = 1'b1;
            if (commit[i]) begin
                d.granted[i] = 1'b0;
                if (loop_mode) d.settle[i] = SETTLE_INIT;
                else           d.valid[i]  = 1'b0;
            end
            if (flush_vld && ((IDXW'(i) - start) > flush_age)) begin
                d.valid[i]   = 1'b0;
                d.granted[i] = 1'b0;
            end
        end
        for (int p = 0; p < NUM_INS; p++) begin
            if (ins_vld[p]) begin
                d.valid[ins_row[p]]   = 1'b1;
                d.granted[ins_row[p]] = 1'b0;
                d.src[ins_row[p]]     = ins_src[p];
                d.dst[ins_row[p]]     = ins_dst[p];
                d.settle[ins_row[p]]  = SETTLE_INIT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.valid   <= '0;
            q.granted <= '0;
            q.src     <= '0;
            q.dst     <= '0;
            q.settle  <= '0;
            q.hop     <= '1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/wk_logreg_sched_chk.sv
`timescale 1ns/1ps
module wk_logreg_sched_chk #(
    parameter int ROWS    = 16,
    parameter int LREGS   = 8,
    parameter int SEG     = 4,
    parameter int ISSUE_W = 2,
    parameter int HOP     = 8,
    parameter int NUM_INS = 4,
    parameter int IDXW    = 4,
    parameter int SEGW    = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [SEGW-1:0]               arch_seg,
    input logic                          loop_mode,
    input logic [NUM_INS-1:0]            ins_vld,
    input logic [NUM_INS-1:0][IDXW-1:0]  ins_row,
    input logic [ROWS-1:0]               commit,
    input logic                          flush_vld,
    input logic [IDXW-1:0]               flush_row,
    input logic [ROWS-1:0]               req,
    input logic [ROWS-1:0]               grant
);
    localparam int HOP_ROWS = (HOP < ROWS) ? HOP : ROWS;
    localparam int NHOPS    = ROWS / HOP_ROWS;

    logic [ROWS-1:0] ins_hit;
    logic [ROWS-1:0] flush_hit;
    logic [IDXW-1:0] base;

    assign base = IDXW'(int'(arch_seg) * SEG);

    always_comb begin
        ins_hit = '0;
        for (int p = 0; p < NUM_INS; p++)
            for (int i = 0; i < ROWS; i++)
                if (ins_vld[p] && ins_row[p] == IDXW'(i)) ins_hit[i] = 1'b1;
        for (int i = 0; i < ROWS; i++)
            flush_hit[i] = flush_vld && ((IDXW'(i) - base) > (flush_row - base));
    end

    // R4
    grant_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    // R4
    issue_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) <= ISSUE_W);

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        // R8
        plain_commit_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (commit[i] && !loop_mode && !ins_hit[i]) |=> !req[i]);

        // R9
        flush_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_hit[i] && !ins_hit[i]) |=> !req[i]);

        if (NHOPS > 1) begin : g_settle
            // R7
            fresh_row_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ins_hit[i] |=> !req[i]);
        end
    end
endmodule

bind wk_logreg_sched wk_logreg_sched_chk #(
    .ROWS(ROWS), .LREGS(LREGS), .SEG(SEG), .ISSUE_W(ISSUE_W), .HOP(HOP),
    .NUM_INS(NUM_INS), .IDXW(IDXW), .SEGW(SEGW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .arch_seg(arch_seg), .loop_mode(loop_mode),
    .ins_vld(ins_vld), .ins_row(ins_row), .commit(commit),
    .flush_vld(flush_vld), .flush_row(flush_row), .req(req), .grant(grant)
);

// File: tb/wk_logreg_sched_tb.sv
`timescale 1ns/1ps
module wk_logreg_sched_tb;
    localparam int ROWS = 16, LREGS = 8, NUM_INS = 4, IDXW = 4, SEGW = 2;

    logic                         clk = 1'b0;
    logic                         rst_n;
    logic [SEGW-1:0]              arch_seg;
    logic                         loop_mode;
    logic [NUM_INS-1:0]           ins_vld;
    logic [NUM_INS-1:0][IDXW-1:0] ins_row;
    logic [NUM_INS-1:0][LREGS-1:0] ins_src;
    logic [NUM_INS-1:0][LREGS-1:0] ins_dst;
    logic [ROWS-1:0]              commit;
    logic                         flush_vld;
    logic [IDXW-1:0]              flush_row;
    logic [ROWS-1:0]              req;
    logic [ROWS-1:0]              grant;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [ROWS-1:0] g;
        string           tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    wk_logreg_sched u_dut (
        .clk(clk), .rst_n(rst_n), .arch_seg(arch_seg), .loop_mode(loop_mode),
        .ins_vld(ins_vld), .ins_row(ins_row), .ins_src(ins_src), .ins_dst(ins_dst),
        .commit(commit), .flush_vld(flush_vld), .flush_row(flush_row),
        .req(req), .grant(grant)
    );

    function automatic logic [ROWS-1:0] bit_of(input int i);
        return ROWS'(1) << i;
    endfunction

    task automatic clear_pulses();
        ins_vld   = '0;
        ins_row   = '0;
        ins_src   = '0;
        ins_dst   = '0;
        commit    = '0;
        flush_vld = 1'b0;
        flush_row = '0;
    endtask

    task automatic put(input int p, input int row, input logic [LREGS-1:0] s,
                       input logic [LREGS-1:0] w);
        ins_vld[p] = 1'b1;
        ins_row[p] = IDXW'(row);
        ins_src[p] = s;
        ins_dst[p] = w;
    endtask

    // capture the inputs set so far, then queue the grant expected after that edge
    task automatic tick(input logic [ROWS-1:0] e, input string t);
        exp_t item;
        @(posedge clk);
        #2;
        clear_pulses();
        item.g   = e;
        item.tag = t;
        sb.push_back(item);
    endtask

    // monitor: compares the grant vector half a cycle after each edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (grant !== e.g) begin
                    bad++;
                    $display("FAIL %s: grant=%h expected=%h", e.tag, grant, e.g);
                end
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        arch_seg  = '0;
        loop_mode = 1'b0;
        clear_pulses();
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;

        // R1: idle after reset
        tick('0, "R1 idle grant");
        @(negedge clk);
        total++;
        if (req !== '0) begin
            bad++;
            $display("FAIL R1 idle req: req=%h expected=0", req);
        end
        @(posedge clk);
        #2;

        // R3 serial chain on register 0 (bit 0)
        put(0, 0, 8'h00, 8'h01);
        put(1, 1, 8'h01, 8'h01);
        put(2, 2, 8'h01, 8'h01);
        tick('0, "R7 fresh rows wait");
        tick(bit_of(0), "R3 chain row0");
        tick(bit_of(1), "R3 chain row1 after row0 grant");
        tick(bit_of(2), "R2 chain row2 sources ready");
        tick('0, "R3 chain drained");
        commit = 16'h0007;
        tick('0, "R8 plain commit frees");

        // R4 independent rows, two per cycle
        put(0, 0, 8'h00, 8'h02);
        put(1, 1, 8'h00, 8'h04);
        put(2, 2, 8'h00, 8'h08);
        put(3, 3, 8'h00, 8'h10);
        tick('0, "R7 settle");
        tick(16'h0003, "R4 oldest pair");
        tick(16'h000C, "R4 next pair");
        tick('0, "R4 no regrant");
        commit = 16'h000F;
        tick('0, "R8 free group");

        // R8 loop mode re-arm
        loop_mode = 1'b1;
        put(0, 0, 8'h01, 8'h01);
        put(1, 1, 8'h01, 8'h20);
        tick('0, "R7 loop settle");
        tick(bit_of(0), "R8 loop iter1 row0");
        tick(bit_of(1), "R8 loop iter1 row1");
        commit = bit_of(0);
        tick('0, "R8 rearm settle row0");
        tick(bit_of(0), "R8 loop iter2 row0");
        commit = bit_of(1);
        tick('0, "R8 rearm settle row1");
        tick(bit_of(1), "R8 loop iter2 row1");
        loop_mode = 1'b0;
        commit = 16'h0003;
        tick('0, "R8 plain commit ends loop");
        tick('0, "R8 freed rows stay idle");

        // R6 producer row 6, consumer row 9 across the hop boundary
        put(0, 6, 8'h00, 8'h04);
        put(1, 9, 8'h04, 8'h40);
        tick('0, "R7 hop settle");
        tick(bit_of(6), "R6 producer issues");
        tick('0, "R6 hop register delay");
        tick(bit_of(9), "R6 consumer after hop");
        commit = bit_of(6) | bit_of(9);
        tick('0, "R8 free hop rows");

        // R4 age order with architected segment 2 (rows 8..11)
        arch_seg = 2'd2;
        put(0, 1, 8'h00, 8'h01);
        put(1, 10, 8'h00, 8'h02);
        put(2, 13, 8'h00, 8'h04);
        tick('0, "R7 order settle");
        tick(bit_of(10) | bit_of(13), "R4 oldest from arch segment");
        tick(bit_of(1), "R4 wrapped row youngest");
        commit = bit_of(1) | bit_of(10) | bit_of(13);
        tick('0, "R8 free order rows");

        // R5 row 9 in the architected segment ignores younger writer row 2
        put(0, 2, 8'h00, 8'h08);
        put(1, 9, 8'h08, 8'h00);
        tick('0, "R7 arch settle");
        tick(bit_of(2) | bit_of(9), "R5 architected operands ready");
        commit = bit_of(2) | bit_of(9);
        tick('0, "R8 free arch rows");

        // R9 flush rows younger than row 1
        arch_seg = 2'd0;
        put(0, 0, 8'h01, 8'h01);
        put(1, 1, 8'h01, 8'h01);
        put(2, 2, 8'h01, 8'h01);
        put(3, 3, 8'h01, 8'h01);
        tick('0, "R7 flush settle");
        flush_vld = 1'b1;
        flush_row = 4'd1;
        tick(bit_of(0), "R9 kept row0 issues");
        tick(bit_of(1), "R9 kept row1 issues");
        tick('0, "R9 flushed row2 absent");
        tick('0, "R9 flushed row3 absent");
        commit = 16'h0003;
        tick('0, "R8 final free");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule